// File: doc/BRIEF.md
# Pipelined Merge-Exchange Sorter

This block sorts a vector of N unsigned words into ascending order. It is made only of compare-exchange cells, and each cell places the smaller of its two words at the lower index. The cells are grouped into levels. The index pairs for each level follow the merge-exchange schedule. That schedule steps through a stride p, a span q, a residue r and a distance d. Index i is paired with i+d when i+d is in range and the bitwise AND of i and p equals r. Levels are worked out at elaboration from N. A level where an index has no partner passes that word through unchanged.

A register stage follows every level, so the critical path crosses one cell. A new vector can enter on every clock. A valid bit travels with the data, and the result appears a fixed number of clocks later: t·(t+1)/2 clocks, where t = ceil(log2 N). That is 10 clocks for the default N = 16 and 21 clocks for N = 64. Reset clears only the valid bits; the data registers keep whatever they hold.

Words are packed in one flat vector, with word k at bits [k*W +: W] on both the input and the output.

The block has no state machine. It has a single flow:
- Each level stage takes the previous stage's words and valid bit.
- The stage registers them on every clock.

Top module: `sortnet_top`

## Requirements
- R1: When out_valid is high, out_data word k is less than or equal to word k+1 for every k, where word k sits at bits [k*W +: W].
- R2: The output words are exactly the input words of the matching vector, rearranged, with duplicates kept.
- R3: A vector accepted with in_valid high at a clock edge is presented with out_valid high exactly LEVELS = t·(t+1)/2 clock edges later, which is 10 for N = 16.
- R4: Vectors presented on consecutive clocks are all accepted, and they leave on consecutive clocks in the order they arrived.
- R5: While rst is high at a clock edge, every valid bit is cleared. Vectors in flight at that edge never appear, and out_valid stays low after reset until a new vector has crossed all levels.
- R6: A clock with in_valid low produces no output beat: out_valid is low exactly LEVELS clocks later.
- R7: Vectors that are all equal, already sorted, reverse sorted, or that hold the values 0 and 2^W-1 are sorted correctly.
- R8: After every level, each compare-exchanged pair (i, i+d) of that level holds the smaller word at index i, and the sum of all words is the same as before the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks in_data as a vector to sort |
| in_data | input | N*W | N unsigned words, word k at bits [k*W +: W] |
| out_valid | output | 1 | Marks out_data as a sorted vector |
| out_data | output | N*W | N words in ascending order, word 0 smallest |

## Verification
A wrong pairing or a flipped compare in one level leaves the words out of order. It shows as a miscompare against a software-sorted copy on the first output beat that carries an affected vector, LEVELS clocks after that vector entered. A broken valid pipeline shows as out_valid in the wrong cycle: an early, late, lost or extra beat is caught in the cycle where the beat is expected. The bench uses all-equal, monotonic and extreme-value vectors, back-to-back streams with gaps, and a reset while vectors are in flight. These expose cells that are missing or in the wrong place, lost duplicates and valid bits that survive reset.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

    // Number of compare levels the merge-exchange schedule produces for n inputs.
    function automatic int mx_level_count(input int n);
        int t;
        int p;
        int q;
        int qold;
        int k;
        t = $clog2(n);
        p = 1 << (t - 1);
        k = 0;
        while (p > 0) begin
            q = 1 << (t - 1);
            qold = 0;
            while (qold != p) begin
                k++;
                qold = q;
                q = q / 2;
            end
            p = p / 2;
        end
        return k;
    endfunction

    // Schedule value of one level: sel 0 gives p, 1 gives r, 2 gives d.
    function automatic int mx_level_param(input int n, input int lvl, input int sel);
        int t;
        int p;
        int q;
        int r;
        int d;
        int qold;
        int k;
        t = $clog2(n);
        p = 1 << (t - 1);
        k = 0;
        while (p > 0) begin
            q = 1 << (t - 1);
            r = 0;
            d = p;
            qold = 0;
            while (qold != p) begin
                if (k == lvl) begin
                    if (sel == 0) return p;
                    if (sel == 1) return r;
                    return d;
                end
                k++;
                qold = q;
                d = q - p;
                q = q / 2;
                r = p;
            end
            p = p / 2;
        end
        return 0;
    endfunction

    // True when index i is the lower end of a compare-exchange pair.
    function automatic bit mx_is_low(input int n, input int p, input int r,
                                     input int d, input int i);
        return (d > 0) && (i < n - d) && ((i & p) == r);
    endfunction

endpackage

// File: rtl/sortnet_cmpx.sv
module sortnet_cmpx #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic swap;

    always_comb begin
        swap = (a > b);
        lo   = swap ? b : a;
        hi   = swap ? a : b;
    end

endmodule

// File: rtl/sortnet_stage.sv
module sortnet_stage
    import sortnet_pkg::*;
#(
    parameter int N   = 16,
    parameter int W   = 16,
    parameter int LVL = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [N-1:0][W-1:0] in_dat,
    output logic                out_vld,
    output logic [N-1:0][W-1:0] out_dat
);
    localparam int P  = mx_level_param(N, LVL, 0);
    localparam int R  = mx_level_param(N, LVL, 1);
    localparam int D  = mx_level_param(N, LVL, 2);
    localparam int SW = W + $clog2(N);

    logic [W-1:0] nxt [N];

    for (genvar j = 0; j < N; j++) begin : g_lane
        if (mx_is_low(N, P, R, D, j)) begin : g_cell
            sortnet_cmpx #(.W(W)) u_cmpx (
                .a  (in_dat[j]),
                .b  (in_dat[j+D]),
                .lo (nxt[j]),
                .hi (nxt[j+D])
            );
            // R8: lower index of every pair holds the smaller word after the register
            assert_pair_order_R8: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> (out_dat[j] <= out_dat[j+D]));
        end else if (!(j >= D && mx_is_low(N, P, R, D, j - D))) begin : g_pass
            assign nxt[j] = in_dat[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < N; j++) begin
            out_dat[j] <= nxt[j];
        end
    end

    logic [SW-1:0] sum_in;
    logic [SW-1:0] sum_out;

    always_comb begin
        sum_in  = '0;
        sum_out = '0;
        for (int j = 0; j < N; j++) begin
            sum_in  = sum_in  + SW'(in_dat[j]);
            sum_out = sum_out + SW'(out_dat[j]);
        end
    end

    // R8: a level only rearranges words, so their total is unchanged
    assert_sum_kept_R8: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (sum_out == $past(sum_in)));

endmodule

// File: rtl/sortnet_top.sv
module sortnet_top
    import sortnet_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_data,
    output logic           out_valid,
    output logic [N*W-1:0] out_data
);
    localparam int LEVELS = mx_level_count(N);

    logic [N-1:0][W-1:0] dat [LEVELS+1];
    logic                vld [LEVELS+1];

    assign dat[0] = in_data;
    assign vld[0] = in_valid;

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        sortnet_stage #(.N(N), .W(W), .LVL(l)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (vld[l]),
            .in_dat  (dat[l]),
            .out_vld (vld[l+1]),
            .out_dat (dat[l+1])
        );
    end

    assign out_valid = vld[LEVELS];
    assign out_data  = dat[LEVELS];

    for (genvar k = 0; k < N - 1; k++) begin : g_chk
        // R1: neighbouring output words are in ascending order
        assert_out_sorted_R1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_data[k*W +: W] <= out_data[(k+1)*W +: W]));
    end

    // R5: a reset edge leaves no beat at the output on the following cycle
    assert_reset_clears_R5: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sortnet_top_test.sv
module sortnet_top_test;
    localparam int N      = 16;
    localparam int W      = 16;
    localparam int LEVELS = 10;
    localparam int CLK_T  = 10;
    localparam int NPAT   = 10;

    // Table of stimulus: pattern kind and seed word; expected results are sorted copies.
    // kinds: 0 all equal, 1 ascending, 2 descending, 3 min/max alternating,
    //        4 random, 5 all max with one min, 6 random with repeats
    localparam int PAT_KIND [NPAT] = '{0, 1, 2, 3, 4, 5, 6, 0, 4, 3};
    localparam int PAT_SEED [NPAT] = '{16'h1234, 3, 100, 0, 7, 9, 11, 16'hffff, 21, 5};

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           out_valid;
    logic [N*W-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [N*W-1:0] q_v [$];
    int             q_t [$];

    sortnet_top #(.N(N), .W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_T/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [N*W-1:0] make_vec(input int kind, input int seed);
        logic [N*W-1:0] v;
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] w;
            case (kind)
                0: w = W'(seed);
                1: w = W'(seed + k * 3);
                2: w = W'(seed + (N - k) * 5);
                3: w = (k % 2 == 0) ? '1 : '0;
                5: w = (k == N / 2) ? '0 : '1;
                6: w = W'($urandom_range(3, 0));
                default: w = W'($urandom);
            endcase
            v[k*W +: W] = w;
        end
        return v;
    endfunction

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [N*W-1:0] r;
        for (int k = 0; k < N; k++) a[k] = v[k*W +: W];
        for (int i = 1; i < N; i++) begin
            for (int j = i; j > 0; j--) begin
                if (a[j-1] > a[j]) begin
                    logic [W-1:0] t;
                    t = a[j]; a[j] = a[j-1]; a[j-1] = t;
                end
            end
        end
        for (int k = 0; k < N; k++) r[k*W +: W] = a[k];
        return r;
    endfunction

    task automatic send(input logic [N*W-1:0] v);
        @(posedge clk); #2;
        in_valid = 1'b1;
        in_data  = v;
        q_v.push_back(ref_sort(v));
        q_t.push_back(cyc);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            in_valid = 1'b0;
            in_data  = '0;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && q_t.size() > 0; i++) idle(1);
        idle(2);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Output monitor: R1, R2, R8 (full order and contents), R3 (latency), R4, R6 (beat timing)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (q_t.size() > 0 && q_t[0] + LEVELS == cyc) begin
                n_checks++;
                if (!out_valid) begin
                    n_fail++;
                    $display("FAIL R3 out_valid at cycle %0d: got %b exp 1", cyc, out_valid);
                end else if (out_data !== q_v[0]) begin
                    n_fail++;
                    $display("FAIL R1/R2 sorted words: got %h exp %h", out_data, q_v[0]);
                end
                void'(q_v.pop_front());
                void'(q_t.pop_front());
            end else if (out_valid) begin
                n_checks++;
                n_fail++;
                $display("FAIL R6 unexpected beat at cycle %0d: got 1 exp 0", cyc);
            end
        end
    end

    initial begin
        #(CLK_T * 150000);
        n_fail++;
        $display("FAIL watchdog expired: got timeout exp completion");
        summary();
    end

    initial begin
        // R5: reset state
        repeat (3) @(posedge clk);
        #2;
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 out_valid in reset: got %b exp 0", out_valid);
        end
        rst = 1'b0;

        // Table walk, back to back; R7 corner patterns included
        for (int i = 0; i < NPAT; i++) send(make_vec(PAT_KIND[i], PAT_SEED[i]));
        drain();

        // R4: long back-to-back random stream
        for (int i = 0; i < 300; i++) send(make_vec(4, 0));
        drain();

        // R6: gaps between vectors
        for (int i = 0; i < 30; i++) begin
            send(make_vec(i % 7, i * 13));
            idle(i % 3);
        end
        drain();

        // R5: reset while vectors are in flight discards them
        for (int i = 0; i < 6; i++) send(make_vec(4, 0));
        @(posedge clk); #2;
        rst = 1'b1;
        in_valid = 1'b0;
        q_v.delete();
        q_t.delete();
        repeat (2) @(posedge clk);
        #2;
        rst = 1'b0;
        for (int i = 0; i < LEVELS + 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R5 stale beat after reset: got %b exp 0", out_valid);
            end
        end

        // R7: extremes after reset, then one ordinary vector to show recovery
        send(make_vec(5, 0));
        send(make_vec(3, 0));
        send(make_vec(0, 0));
        send(make_vec(2, 16'hff00));
        drain();

        summary();
    end

endmodule